// File: doc/BRIEF.md
# Synchronous SRAM Output Pipeline and Deselect Control

This block is the read and write side of a synchronous SRAM bank as seen from the data bus. Each rising clock edge captures one command, formed from the chip select, the write controls, the address and the write data. A captured read returns array data on the bus. A captured write updates some or all byte lanes of one word. A captured deselect takes the bus off. The block drives the bus value and a separate drive-enable. A surrounding pad ring turns these two signals into a tri-state bus.

Two static mode pins set the read timing. One picks flow-through reads, where array data goes straight to the bus, or pipelined reads, where the data passes through one more clocked register. The other picks how quickly a deselect releases the bus in pipelined mode: either one stage ahead of read data, or at the same depth as read data.

The output-enable and sleep inputs act on the drive-enable combinationally, with no clock edge involved. Sleep also makes the block ignore new commands, and the array contents are kept.

Top module: `ssram_out_pipe`

## Requirements
- R1: While reset is held and after it is released, the drive-enable `dqOe` is low until a read has been captured.
- R2: In flow-through mode (`pipeMode`=0), a read captured at edge k drives the addressed word with `dqOe` high during the cycle after edge k.
- R3: In pipelined mode (`pipeMode`=1), a read captured at edge k is not driven after edge k. It is driven during the cycle after edge k+1.
- R4: Reads on consecutive edges produce one bus beat each, in the same order, in both modes.
- R5: With `pipeMode`=1 and `dualDeselect`=0, a deselect (`chipSel`=0) captured at edge j holds `dqOe` low after edge j, even when read data was loaded into the output register at edge j.
- R6: With `pipeMode`=1 and `dualDeselect`=1, read data loaded at edge j is driven after edge j although a deselect was captured at edge j, and the bus is released after edge j+1.
- R7: With `globalWr`=0, a write occurs only when `byteWrEn`=1 and at least one bit of `byteSel` is set. Lane i is bits [8i+7:8i] and is written only when `byteSel[i]`=1. With `byteWrEn`=1 and `byteSel`=0, the command is a read.
- R8: `globalWr`=1 together with `chipSel`=1 writes every lane, whatever `byteWrEn` and `byteSel` say.
- R9: A read of an address captured on the edge right after a write to it returns the newly written lanes.
- R10: `outEn`=0 forces `dqOe` low at once, with no clock edge. Raising it again restores the drive within the same cycle.
- R11: `sleep`=1 forces `dqOe` low at once. Commands captured while sleep is high have no effect, and the array keeps its contents.
- R12: In flow-through mode, `dualDeselect` has no effect: a deselect captured at edge j releases the bus after edge j in both settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| chipSel | input | 1 | 1 selects the bank; 0 is a deselect command |
| byteWrEn | input | 1 | Enables per-lane write selects |
| byteSel | input | LANES | Per-lane write select |
| globalWr | input | 1 | Writes all lanes |
| addr | input | ADDR_W | Word address |
| wrData | input | LANES*LANE_W | Write data, captured with the command |
| pipeMode | input | 1 | 1 pipelined reads, 0 flow-through |
| dualDeselect | input | 1 | 1 deselect at read depth, 0 one stage early (tie-off default) |
| outEn | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| dqOut | output | LANES*LANE_W | Bus data value |
| dqOe | output | 1 | Bus drive-enable |

## Verification
Read streams are run in flow-through mode and in pipelined mode. This confirms that the first beat lands one cycle later with pipelining and that back-to-back reads still give one beat per cycle. Read-then-deselect sequences are run with both deselect settings. In pipelined mode the two settings must give different release cycles; in flow-through mode they must give the same one. Writes with all lanes, with one lane, and with byte-write enable but no lane selected separate partial writes, global writes and writes that silently turn into reads. Each write is read back on the next edge. Toggling output enable and sleep in the middle of a cycle shows that they act without a clock. Writes issued during sleep show that they leave the array untouched.

// File: rtl/ssram_out_pkg.sv
package ssram_out_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_DESEL = 2'd3
  } cmdKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load address and write data registers
    logic commit;    // write the captured word into the array
    logic loadOut;   // load the pipelined output register
  } dpStrobe_t;

endpackage

// File: rtl/ssram_out_ctrl.sv
module ssram_out_ctrl
  import ssram_out_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             byteWrEn,
  input  logic [LANES-1:0] byteSel,
  input  logic             globalWr,
  input  logic             pipeMode,
  input  logic             dualDeselect,
  input  logic             outEn,
  input  logic             sleep,
  output dpStrobe_t        strb,
  output logic [LANES-1:0] commitLanes,
  output logic             busDrive
);

  cmdKind_e         inKind;
  logic [LANES-1:0] inLanes;
  logic             anyWrite;

  cmdKind_e         s1Kind;
  logic [LANES-1:0] s1Lanes;
  logic             s2Read;

  logic s1Read, s1Write, s1Desel;
  logic driveBase;
  logic earlyRelease;

  // Command decode at the input side
  always_comb begin
    anyWrite = globalWr | (byteWrEn & (|byteSel));
    inLanes  = globalWr ? {LANES{1'b1}} : byteSel;
    if (sleep)         inKind = CMD_NOP;
    else if (!chipSel) inKind = CMD_DESEL;
    else if (anyWrite) inKind = CMD_WRITE;
    else               inKind = CMD_READ;
  end

  // Input register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Kind  <= CMD_NOP;
      s1Lanes <= '0;
    end else begin
      s1Kind  <= inKind;
      s1Lanes <= (inKind == CMD_WRITE) ? inLanes : '0;
    end
  end

  assign s1Read  = (s1Kind == CMD_READ);
  assign s1Write = (s1Kind == CMD_WRITE);
  assign s1Desel = (s1Kind == CMD_DESEL);

  // Read-valid flag aligned with the output register
  always_ff @(posedge clk) begin
    if (!rstN) s2Read <= 1'b0;
    else       s2Read <= s1Read;
  end

  always_comb begin
    strb.capture = ~sleep;
    strb.commit  = s1Write;
    strb.loadOut = s1Read;
    commitLanes  = s1Write ? s1Lanes : '0;
  end

  // Single-cycle deselect cuts the pipelined beat one stage early
  assign earlyRelease = ~dualDeselect & s1Desel;
  assign driveBase    = pipeMode ? (s2Read & ~earlyRelease) : s1Read;
  assign busDrive     = driveBase & outEn & ~sleep;

  // R2: flow-through drive follows a read captured on the last edge
  a_r2_ft_depth: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && busDrive) |-> $past(inKind == CMD_READ));

  // R3: pipelined drive follows a read one stage further back
  a_r3_pipe_depth: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && busDrive) |-> $past(s1Kind == CMD_READ));

  // R5: single-cycle deselect releases right after capture
  a_r5_scd_release: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !dualDeselect && $past(inKind == CMD_DESEL)) |-> !busDrive);

  // R8: global write commits every lane
  a_r8_global_all: assert property (@(posedge clk) disable iff (!rstN)
    (globalWr && chipSel && !sleep) |=> (commitLanes == {LANES{1'b1}}));

  // R11: nothing captured during sleep reaches the array
  a_r11_sleep_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !strb.commit);

endmodule

// File: rtl/ssram_out_dp.sv
module ssram_out_dp
  import ssram_out_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [LANES-1:0]        commitLanes,
  input  logic                    pipeMode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] dqOut
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] s1Addr;
  logic [DATA_W-1:0] s1Data;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] outReg;

  // Address and write data captured with the command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Addr <= '0;
      s1Data <= '0;
    end else if (strb.capture) begin
      s1Addr <= addr;
      s1Data <= wrData;
    end
  end

  // One storage array per byte lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < DEPTH; w++) laneMem[w] <= '0;
      end else if (strb.commit && commitLanes[i]) begin
        laneMem[s1Addr] <= s1Data[i*LANE_W +: LANE_W];
      end
    end

    assign rdData[i*LANE_W +: LANE_W] = laneMem[s1Addr];

    // R7: a selected lane takes the captured byte
    a_r7_lane_write: assert property (@(posedge clk) disable iff (!rstN)
      (strb.commit && commitLanes[i]) |=>
        (laneMem[$past(s1Addr)] == $past(s1Data[i*LANE_W +: LANE_W])));

    // R7: an unselected lane keeps its byte
    a_r7_lane_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strb.commit && !commitLanes[i]) |=>
        (laneMem[$past(s1Addr)] == $past(laneMem[s1Addr])));
  end

  // Pipelined output register
  always_ff @(posedge clk) begin
    if (!rstN)             outReg <= '0;
    else if (strb.loadOut) outReg <= rdData;
  end

  assign dqOut = pipeMode ? outReg : rdData;

endmodule

// File: rtl/ssram_out_pipe.sv
module ssram_out_pipe
  import ssram_out_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    chipSel,
  input  logic                    byteWrEn,
  input  logic [LANES-1:0]        byteSel,
  input  logic                    globalWr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    pipeMode,
  input  logic                    dualDeselect,
  input  logic                    outEn,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);

  dpStrobe_t        strb;
  logic [LANES-1:0] commitLanes;

  ssram_out_ctrl #(.LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .chipSel      (chipSel),
    .byteWrEn     (byteWrEn),
    .byteSel      (byteSel),
    .globalWr     (globalWr),
    .pipeMode     (pipeMode),
    .dualDeselect (dualDeselect),
    .outEn        (outEn),
    .sleep        (sleep),
    .strb         (strb),
    .commitLanes  (commitLanes),
    .busDrive     (dqOe)
  );

  ssram_out_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .commitLanes (commitLanes),
    .pipeMode    (pipeMode),
    .addr        (addr),
    .wrData      (wrData),
    .dqOut       (dqOut)
  );

endmodule

// File: tb/ssram_out_pipe_bench.sv
module ssram_out_pipe_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chipSel, byteWrEn, globalWr, pipeMode, dualDeselect, outEn, sleep;
  logic [1:0]  byteSel;
  logic [3:0]  addr;
  logic [15:0] wrData;
  logic [15:0] dqOut;
  logic        dqOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ssram_out_pipe u_ssram_out_pipe (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .byteWrEn(byteWrEn),
    .byteSel(byteSel), .globalWr(globalWr), .addr(addr), .wrData(wrData),
    .pipeMode(pipeMode), .dualDeselect(dualDeselect), .outEn(outEn),
    .sleep(sleep), .dqOut(dqOut), .dqOe(dqOe)
  );

  typedef struct packed {
    logic        pipe;
    logic        dcd;
    logic        sel;
    logic        bwe;
    logic [1:0]  bsel;
    logic        gw;
    logic [3:0]  a;
    logic [15:0] wd;
    logic        eOe;
    logic [15:0] eData;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 29;
  // Each entry: inputs for one edge, expected bus in the cycle after it
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b1,4'd1,16'hA1A1,1'b0,16'h0000,8'd8},  // R8 write
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b1,4'd2,16'hB2B2,1'b0,16'h0000,8'd8},
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b1,16'hA1A1,8'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,4'd2,16'h0000,1'b1,16'hB2B2,8'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd12}, // R12 scd
    '{1'b0,1'b0,1'b1,1'b1,2'b01,1'b0,4'd1,16'h0055,1'b0,16'h0000,8'd7},  // R7 lane0
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b1,16'hA155,8'd9},  // R9
    '{1'b0,1'b0,1'b1,1'b1,2'b00,1'b0,4'd2,16'h1234,1'b1,16'hB2B2,8'd7},  // R7 no lane
    '{1'b0,1'b0,1'b1,1'b1,2'b01,1'b1,4'd2,16'hCCDD,1'b0,16'h0000,8'd8},  // R8
    '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,4'd2,16'h0000,1'b1,16'hCCDD,8'd8},
    '{1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd12}, // R12 dcd
    '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd3},
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b0,16'h0000,8'd3},  // R3 not yet
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,4'd2,16'h0000,1'b1,16'hA155,8'd3},  // R3
    '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd5},  // R5 cut
    '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd5},
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b0,16'h0000,8'd3},
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b1,4'd3,16'h3333,1'b1,16'hA155,8'd4},
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,4'd3,16'h0000,1'b0,16'h0000,8'd3},
    '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b1,16'h3333,8'd9},  // R9 pipe
    '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd5},  // R5 cut
    '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd6},
    '{1'b1,1'b1,1'b1,1'b0,2'b00,1'b0,4'd2,16'h0000,1'b0,16'h0000,8'd3},
    '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b1,16'hCCDD,8'd6},  // R6 held
    '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd6},  // R6 off
    '{1'b1,1'b1,1'b1,1'b0,2'b00,1'b0,4'd3,16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b1,1'b1,1'b0,2'b00,1'b0,4'd1,16'h0000,1'b1,16'h3333,8'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b1,16'hA155,8'd6},
    '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,4'd0,16'h0000,1'b0,16'h0000,8'd6}
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic checkBus(input string tag, input logic eOe, input logic [15:0] eData);
    checks++;
    if (dqOe !== eOe || (eOe && dqOut !== eData)) begin
      failures++;
      $display("FAIL %s: dqOe=%0b dqOut=%h expected dqOe=%0b dqOut=%h",
               tag, dqOe, dqOut, eOe, eData);
    end
  endtask

  task automatic drive(input logic s, input logic bwe, input logic [1:0] bs,
                       input logic gw, input logic [3:0] a, input logic [15:0] d);
    chipSel = s; byteWrEn = bwe; byteSel = bs; globalWr = gw; addr = a; wrData = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pipeMode = 1'b0; dualDeselect = 1'b0; outEn = 1'b1; sleep = 1'b0;
    drive(1'b0, 1'b0, 2'b00, 1'b0, 4'd0, 16'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBus("R1 in reset", 1'b0, 16'h0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkBus("R1 after reset", 1'b0, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      pipeMode = TBL[i].pipe; dualDeselect = TBL[i].dcd;
      drive(TBL[i].sel, TBL[i].bwe, TBL[i].bsel, TBL[i].gw, TBL[i].a, TBL[i].wd);
      @(posedge clk); @(negedge clk);
      checkBus($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].eOe, TBL[i].eData);
    end

    // R10 and R11: asynchronous gating, pipelined dual-cycle deselect
    pipeMode = 1'b1; dualDeselect = 1'b1;
    drive(1'b1, 1'b0, 2'b00, 1'b0, 4'd1, 16'h0);
    @(posedge clk); @(negedge clk);
    drive(1'b0, 1'b0, 2'b00, 1'b0, 4'd0, 16'h0);
    @(posedge clk); @(negedge clk);
    checkBus("R10 beat before gating", 1'b1, 16'hA155);
    outEn = 1'b0; #1;
    checkBus("R10 outEn low", 1'b0, 16'h0);
    outEn = 1'b1; #1;
    checkBus("R10 outEn restored", 1'b1, 16'hA155);
    sleep = 1'b1; #1;
    checkBus("R11 sleep forces off", 1'b0, 16'h0);

    // R11: writes during sleep are dropped
    @(negedge clk);
    drive(1'b1, 1'b0, 2'b00, 1'b1, 4'd1, 16'hFFFF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkBus("R11 asleep bus", 1'b0, 16'h0);
    sleep = 1'b0;
    drive(1'b1, 1'b0, 2'b00, 1'b0, 4'd1, 16'h0);
    @(posedge clk); @(negedge clk);
    drive(1'b0, 1'b0, 2'b00, 1'b0, 4'd0, 16'h0);
    @(posedge clk); @(negedge clk);
    checkBus("R11 contents kept", 1'b1, 16'hA155);

    done = 1;
    report();
    $finish;
  end

endmodule